// File: doc/BRIEF.md
# Interrupt Vector Read Unit

This block answers processor reads of four vector read registers, each tied to one interrupt priority level of a peripheral bus. A read of one register raises the acknowledge line of that level. The block then waits for a device on the bus to return a 16-bit vector. It hands the vector back to the processor with the upper half of the word filled with ones. If no device answers within a fixed number of cycles, the block drops the acknowledge and completes the read with a bus error instead of data.

The processor read port uses a request/ready handshake. The requester holds `cpu_req_i` and its address until `cpu_ready_o` pulses for one cycle, with the data and the error flag valid in that cycle. Reads coming from the diagnostic side are refused with an error. Only one acknowledge is ever in flight. The raw level request inputs are passed straight through to the processor's cause logic. On this bus a request at a higher level also raises every lower level. Software must therefore read the register of the highest pending level.

Top module: `irq_vector_reader`

## Requirements
- R1: After reset, `cpu_ready_o`, `cpu_err_o` and all four `bus_ack_o` lines are low.
- R2: Byte offsets 0x50, 0x54, 0x58 and 0x5C select acknowledge lines `bus_ack_o[0]` to `bus_ack_o[3]`, which stand for priority levels 14, 15, 16 and 17. Level 17 is the highest.
- R3: An accepted read raises exactly one acknowledge line. That line stays high and unchanged until a vector arrives or the timeout expires, then drops. Each read gives exactly one acknowledge.
- R4: When `bus_vld_i` is sampled high during an acknowledge, the read completes in the next cycle. In that cycle `cpu_ready_o` is high, `cpu_err_o` is low, `cpu_rdata_o[15:0]` equals `bus_vec_i` and `cpu_rdata_o[31:16]` is all ones.
- R5: If no vector arrives, the acknowledge stays high for exactly `TIMEOUT_CYCLES` cycles. The read then completes with `cpu_err_o` high and `cpu_rdata_o` all ones.
- R6: A request with `cpu_diag_i` high raises no acknowledge. It completes in the next cycle with `cpu_err_o` high and `cpu_rdata_o` all ones.
- R7: A request at any offset other than the four register offsets raises no acknowledge. It completes in the next cycle with `cpu_err_o` high and `cpu_rdata_o` all ones.
- R8: `cpu_ready_o` is high for one cycle per read. No acknowledge line is high while `cpu_ready_o` is high.
- R9: `irq_pending_o` follows `bus_irq_i` in the same cycle, including nested patterns where lower levels are raised alongside a higher one.
- R10: A vector sampled on the last cycle before the timeout completes the read with data, not with an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_req_i | input | 1 | Read request, held until ready |
| cpu_addr_i | input | ADDR_W | Byte offset of the register |
| cpu_diag_i | input | 1 | Request comes from the diagnostic side |
| cpu_ready_o | output | 1 | One-cycle completion pulse |
| cpu_rdata_o | output | DATA_W | Read data |
| cpu_err_o | output | 1 | Bus error on completion |
| bus_ack_o | output | 4 | Interrupt acknowledge, one line per level |
| bus_vec_i | input | VEC_W | Vector from the answering device |
| bus_vld_i | input | 1 | Vector valid |
| bus_irq_i | input | 4 | Raw level requests |
| irq_pending_o | output | 4 | Pending levels to cause logic |

## Verification
The bench builds the block with `TIMEOUT_CYCLES` set to 16 and keeps the address and data widths at their defaults. With this timeout the exact edge of the window can be checked at low cost. A device that answers on cycle 15 of the acknowledge gets its vector through. A device that answers on cycle 16 is never seen, so the read ends with an error after exactly 16 acknowledge cycles. The model device also counts acknowledge cycles and records which lines were raised for every read. From these it checks the level mapping and the single-acknowledge rule across all four registers.

// File: rtl/vrd_pkg.sv
package vrd_pkg;
  localparam int unsigned VRD_LEVELS = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACK  = 2'd1,
    ST_RESP = 2'd2
  } vrd_state_e;
endpackage

// File: rtl/vrd_decode.sv
module vrd_decode #(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned BASE_OFFSET = 'h50,
  parameter int unsigned LEVELS      = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              diag_i,
  output logic              hit_o,
  output logic [LEVELS-1:0] lvl_oh_o
);
  logic [LEVELS-1:0] match;

  // one word per level, lowest level at the base offset
  for (genvar i = 0; i < LEVELS; i++) begin : g_lvl
    assign match[i] = (addr_i == ADDR_W'(BASE_OFFSET + 4 * i));
  end

  assign hit_o    = (|match) & ~diag_i;
  assign lvl_oh_o = diag_i ? '0 : match;
endmodule

// File: rtl/vrd_timer.sv
module vrd_timer #(
  parameter int unsigned LIMIT = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expire_o
);
  localparam int unsigned CNT_W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!run_i)        cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = run_i && (cnt_q == LAST);

  p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  p_cnt_restart_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0);
endmodule

// File: rtl/vrd_format.sv
module vrd_format #(
  parameter int unsigned VEC_W  = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic [VEC_W-1:0]  vec_i,
  input  logic              err_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned PAD_W = DATA_W - VEC_W;

  always_comb begin
    if (err_i) data_o = '1;
    else       data_o = {{PAD_W{1'b1}}, vec_i};
  end
endmodule

// File: rtl/irq_vector_reader.sv
module irq_vector_reader
  import vrd_pkg::*;
#(
  parameter int unsigned ADDR_W         = 8,
  parameter int unsigned VEC_W          = 16,
  parameter int unsigned DATA_W         = 32,
  parameter int unsigned BASE_OFFSET    = 'h50,
  parameter int unsigned TIMEOUT_CYCLES = 256
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cpu_req_i,
  input  logic [ADDR_W-1:0]     cpu_addr_i,
  input  logic                  cpu_diag_i,
  output logic                  cpu_ready_o,
  output logic [DATA_W-1:0]     cpu_rdata_o,
  output logic                  cpu_err_o,
  output logic [VRD_LEVELS-1:0] bus_ack_o,
  input  logic [VEC_W-1:0]      bus_vec_i,
  input  logic                  bus_vld_i,
  input  logic [VRD_LEVELS-1:0] bus_irq_i,
  output logic [VRD_LEVELS-1:0] irq_pending_o
);
  localparam int unsigned LEVELS = VRD_LEVELS;

  vrd_state_e        state_q;
  logic [LEVELS-1:0] ack_q;
  logic              ready_q;
  logic              err_q;
  logic [DATA_W-1:0] rdata_q;

  logic              hit;
  logic [LEVELS-1:0] lvl_oh;
  logic              expire;
  logic              rsp_err;
  logic [DATA_W-1:0] rsp_data;

  vrd_decode #(
    .ADDR_W     (ADDR_W),
    .BASE_OFFSET(BASE_OFFSET),
    .LEVELS     (LEVELS)
  ) u_decode (
    .addr_i  (cpu_addr_i),
    .diag_i  (cpu_diag_i),
    .hit_o   (hit),
    .lvl_oh_o(lvl_oh)
  );

  vrd_timer #(
    .LIMIT(TIMEOUT_CYCLES)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (state_q == ST_ACK),
    .expire_o(expire)
  );

  // error unless a vector is arriving during an acknowledge
  assign rsp_err = !((state_q == ST_ACK) && bus_vld_i);

  vrd_format #(
    .VEC_W (VEC_W),
    .DATA_W(DATA_W)
  ) u_format (
    .vec_i (bus_vec_i),
    .err_i (rsp_err),
    .data_o(rsp_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ack_q   <= '0;
      ready_q <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          ready_q <= 1'b0;
          if (cpu_req_i) begin
            if (hit) begin
              state_q <= ST_ACK;
              ack_q   <= lvl_oh;
            end else begin
              state_q <= ST_RESP;
              ready_q <= 1'b1;
              err_q   <= 1'b1;
              rdata_q <= rsp_data;
            end
          end
        end
        ST_ACK: begin
          // a vector on the last cycle beats the timeout
          if (bus_vld_i || expire) begin
            state_q <= ST_RESP;
            ack_q   <= '0;
            ready_q <= 1'b1;
            err_q   <= rsp_err;
            rdata_q <= rsp_data;
          end
        end
        default: begin
          state_q <= ST_IDLE;
          ready_q <= 1'b0;
        end
      endcase
    end
  end

  assign cpu_ready_o   = ready_q;
  assign cpu_err_o     = err_q;
  assign cpu_rdata_o   = rdata_q;
  assign bus_ack_o     = ack_q;
  assign irq_pending_o = bus_irq_i;

  p_ack_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bus_ack_o));
  p_ack_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_ack_o != '0) |=> (bus_ack_o == '0) || $stable(bus_ack_o));
  p_vec_ok_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACK && bus_vld_i) |=>
      cpu_ready_o && !cpu_err_o && cpu_rdata_o[VEC_W-1:0] == $past(bus_vec_i)
      && (&cpu_rdata_o[DATA_W-1:VEC_W]));
  p_timeout_err_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACK && expire && !bus_vld_i) |=>
      cpu_ready_o && cpu_err_o && (&cpu_rdata_o) && bus_ack_o == '0);
  p_diag_refused_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && cpu_req_i && cpu_diag_i) |=>
      bus_ack_o == '0 && cpu_err_o && cpu_ready_o);
  p_ready_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ready_o |=> !cpu_ready_o);
  p_no_ack_on_ready_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ready_o |-> bus_ack_o == '0);
endmodule

// File: tb/sim_irq_vector_reader.sv
`timescale 1ns/1ps
module sim_irq_vector_reader;
  localparam int TO = 16;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cpu_req_i = 1'b0;
  logic [7:0]  cpu_addr_i = '0;
  logic        cpu_diag_i = 1'b0;
  logic        cpu_ready_o;
  logic [31:0] cpu_rdata_o;
  logic        cpu_err_o;
  logic [3:0]  bus_ack_o;
  logic [15:0] bus_vec_i = '0;
  logic        bus_vld_i = 1'b0;
  logic [3:0]  bus_irq_i = '0;
  logic [3:0]  irq_pending_o;

  always #4 clk_i = ~clk_i;

  irq_vector_reader #(.TIMEOUT_CYCLES(TO)) u0 (
    .clk_i, .rst_ni, .cpu_req_i, .cpu_addr_i, .cpu_diag_i,
    .cpu_ready_o, .cpu_rdata_o, .cpu_err_o, .bus_ack_o,
    .bus_vec_i, .bus_vld_i, .bus_irq_i, .irq_pending_o
  );

  typedef struct {
    logic [31:0] data;
    logic        err;
    logic [3:0]  mask;
    int          cycles;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // device model state
  int          dev_delay = -1;
  logic [15:0] dev_vec = '0;
  int          dev_idx = 0;
  logic [3:0]  seen_mask = '0;
  int          seen_cycles = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // device: answers dev_delay cycles into the acknowledge, never if negative
  always @(posedge clk_i) begin
    #1;
    if (bus_ack_o != '0) begin
      seen_mask   = seen_mask | bus_ack_o;
      seen_cycles = seen_cycles + 1;
      if (dev_idx == dev_delay) begin
        bus_vld_i = 1'b1;
        bus_vec_i = dev_vec;
      end else begin
        bus_vld_i = 1'b0;
        bus_vec_i = 16'hDEAD;
      end
      dev_idx = dev_idx + 1;
    end else begin
      bus_vld_i = 1'b0;
      dev_idx   = 0;
    end
  end

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni && cpu_ready_o) begin
      if (q.size() == 0) begin
        chk(0, "R8", "unexpected ready", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(cpu_rdata_o == e.data, e.tag, "rdata", cpu_rdata_o, e.data);
        chk(cpu_err_o == e.err, e.tag, "err", 32'(cpu_err_o), 32'(e.err));
        chk(seen_mask == e.mask, e.tag, "ack lines", 32'(seen_mask), 32'(e.mask));
        chk(seen_cycles == e.cycles, e.tag, "ack cycles",
            32'(seen_cycles), 32'(e.cycles));
        chk(bus_ack_o == '0, "R8", "ack during ready", 32'(bus_ack_o), 32'd0);
      end
      seen_mask   = '0;
      seen_cycles = 0;
    end
  end

  // driver: delay < 0 means no device answers
  task automatic do_read(input logic [7:0] addr, input bit diag,
                         input int delay, input logic [15:0] vec,
                         input string tag);
    exp_t e;
    int lvl;
    lvl = -1;
    if (!diag && addr >= 8'h50 && addr <= 8'h5C && addr[1:0] == 2'b00)
      lvl = (int'(addr) - 'h50) / 4;
    e.tag = tag;
    if (lvl < 0) begin
      e.data = '1; e.err = 1'b1; e.mask = '0; e.cycles = 0;
    end else if (delay < 0 || delay >= TO) begin
      e.data = '1; e.err = 1'b1; e.mask = 4'(1 << lvl); e.cycles = TO;
    end else begin
      e.data = {16'hFFFF, vec}; e.err = 1'b0; e.mask = 4'(1 << lvl);
      e.cycles = delay + 1;
    end
    q.push_back(e);
    dev_delay = delay;
    dev_vec   = vec;
    @(negedge clk_i);
    cpu_req_i  = 1'b1;
    cpu_addr_i = addr;
    cpu_diag_i = diag;
    @(negedge clk_i);
    while (!cpu_ready_o) @(negedge clk_i);
    cpu_req_i  = 1'b0;
    cpu_diag_i = 1'b0;
    @(negedge clk_i);
    chk(!cpu_ready_o, "R8", "ready longer than one cycle", 32'(cpu_ready_o), 32'd0);
    chk(bus_ack_o == '0, "R3", "second acknowledge", 32'(bus_ack_o), 32'd0);
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    chk(!cpu_ready_o, "R1", "ready in reset", 32'(cpu_ready_o), 32'd0);
    chk(!cpu_err_o, "R1", "err in reset", 32'(cpu_err_o), 32'd0);
    chk(bus_ack_o == '0, "R1", "ack in reset", 32'(bus_ack_o), 32'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(bus_ack_o == '0 && !cpu_ready_o, "R1", "idle after reset",
        32'({bus_ack_o, cpu_ready_o}), 32'd0);

    // R2 R4: each register, varied delays and vectors
    do_read(8'h50, 0, 0, 16'h1234, "R2 level14 R4");
    do_read(8'h54, 0, 3, 16'h00FF, "R2 level15 R4");
    do_read(8'h58, 0, 7, 16'hA5A5, "R2 level16 R4");
    do_read(8'h5C, 0, 1, 16'h0000, "R2 level17 R4");
    do_read(8'h5C, 0, 2, 16'hFFFF, "R4 all-ones vector");
    // R5 timeout, R10 boundary
    do_read(8'h54, 0, -1, 16'h0, "R5 no answer");
    do_read(8'h58, 0, TO, 16'h4321, "R5 answer too late");
    do_read(8'h50, 0, TO - 1, 16'h7E57, "R10 last-cycle answer");
    // R6 diagnostic refused, R7 bad offsets
    do_read(8'h58, 1, 0, 16'h1111, "R6 diag access");
    do_read(8'h60, 0, 0, 16'h2222, "R7 offset 0x60");
    do_read(8'h52, 0, 0, 16'h3333, "R7 offset 0x52");
    do_read(8'h4C, 0, 0, 16'h4444, "R7 offset 0x4C");
    // back to back after error
    do_read(8'h54, 0, 0, 16'hBEEF, "R3 after error");

    // R9 nested request patterns
    for (int i = 0; i <= 4; i++) begin
      @(negedge clk_i);
      bus_irq_i = 4'((1 << i) - 1);
      #1;
      chk(irq_pending_o == bus_irq_i, "R9", "pending", 32'(irq_pending_o),
          32'(bus_irq_i));
    end
    bus_irq_i = 4'b0100;
    #1;
    chk(irq_pending_o == 4'b0100, "R9", "pending single", 32'(irq_pending_o), 32'h4);

    repeat (3) @(negedge clk_i);
    chk(q.size() == 0, "R8", "reads left without completion", 32'(q.size()), 32'd0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R3 watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule